// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic unit of a small accumulator-style processor. Each cycle it takes two 8-bit operands and an operation code, and it computes an 8-bit result combinationally from those and from its own registered status-flag byte. When `opValid` is high, the flag byte is updated on the next rising clock edge. Only the flags that belong to the chosen operation change. Carry-in for the chained arithmetic and for the rotates comes from the C bit of that register.

The flag byte is laid out from bit 7 down to bit 0 as I (interrupt enable), T (bit store), H (half carry), S (sign), V (overflow), N (negative), Z (zero) and C (carry). S is always recomputed as N XOR V whenever an operation writes N and V.

`resultWe` tells the surrounding datapath whether it should write the result back. It is low for compares, for flag set and clear, for unused codes, and whenever `opValid` is low.

Top module: `alu8_flags`

## Requirements
- R1: Reset clears the flag byte to 0x00. The flag bit order, MSB first, is I, T, H, S, V, N, Z, C. With `opValid` low the flags hold and `resultWe` is 0.
- R2: `opSel` codes are as follows. Arithmetic: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 compare, 5 compare with borrow. Logic: 6 AND, 7 OR, 8 XOR, 13 test. Unary: 9 complement, 10 negate, 11 increment, 12 decrement. Shifts and rotates: 14 shift left, 15 logical shift right, 16 rotate left through C, 17 rotate right through C, 18 arithmetic shift right. Others: 19 nibble swap, 20 load 0xFF, 21 flag set, 22 flag clear. Codes 23 to 31 change nothing. Add and add-with-carry give A+B(+C) and update H, S, V, N, Z and C from the sum.
- R3: Subtract, subtract-with-borrow and negate (0−A) give the difference and update H, S, V, N, Z and C. C and H mean a borrow out of bit 7 and out of bit 3.
- R4: Compares update flags like subtract but drive `resultWe` low. The borrow-chained subtract and compare only ever clear Z: a zero difference leaves Z as it was.
- R5: AND, OR, XOR and test update Z and N, clear V, and set S to N. They leave I, T, H and C unchanged.
- R6: Complement gives 0xFF−A, sets C to 1 and clears V. Negate of 0x80 sets V. Negate sets C exactly when the result is nonzero.
- R7: Increment sets V only when the result is 0x80. Decrement sets V only when the result is 0x7F. Neither changes C or H.
- R8: Each shift and rotate loads C with the bit shifted out. The bit shifted in is 0 for the logical shifts, the old C for the rotates, and bit 7 for the arithmetic shift. V becomes N XOR C, and H is unchanged.
- R9: Nibble swap and load-0xFF write a result and change no flag.
- R10: Flag set and clear write only the flag at index `bitIdx` (0 = C … 7 = I), to 1 or 0 respectively.
- R11: After any operation that writes both N and V, S equals N XOR V.
- R12: No operation changes a flag outside its own set. I and T change only through flag set and clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation is applied to the flags this cycle |
| opSel | input | 5 | Operation code |
| bitIdx | input | 3 | Flag index for flag set and clear |
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand |
| result | output | 8 | Combinational result |
| resultWe | output | 1 | Result should be written back |
| flags | output | 8 | Registered flag byte |

## Verification
The only state in this block is the flag byte, which is visible at the `flags` port. A bad flag therefore shows up in the cycle after the operation that wrote it. If the bad flag is C, it also corrupts the next add-with-carry, borrow or rotate result at once. A bad Z is harder to see: it only appears when a borrow-chained compare runs on an equal byte and the stale Z survives. For that reason the bench runs multi-byte compare chains and checks the flags after every operation.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OPC_W  = 5;
  localparam int FLAG_W = 8;
  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_N = 2;
  localparam int FLAG_V = 3;
  localparam int FLAG_S = 4;
  localparam int FLAG_H = 5;

  localparam logic [FLAG_W-1:0] MASK_ARITH = 8'b0011_1111;
  localparam logic [FLAG_W-1:0] MASK_LOGIC = 8'b0001_1110;
  localparam logic [FLAG_W-1:0] MASK_SHIFT = 8'b0001_1111;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_CP   = 5'd4,  OP_CPC  = 5'd5,  OP_AND  = 5'd6,  OP_OR   = 5'd7,
    OP_EOR  = 5'd8,  OP_COM  = 5'd9,  OP_NEG  = 5'd10, OP_INC  = 5'd11,
    OP_DEC  = 5'd12, OP_TST  = 5'd13, OP_LSL  = 5'd14, OP_LSR  = 5'd15,
    OP_ROL  = 5'd16, OP_ROR  = 5'd17, OP_ASR  = 5'd18, OP_SWAP = 5'd19,
    OP_SER  = 5'd20, OP_FSET = 5'd21, OP_FCLR = 5'd22
  } aluOp_e;

  typedef struct packed {
    logic [FLAG_W-1:0] flagMask;
    logic              resultWe;
    logic              carryUse;
    logic              zChain;
    logic              subMode;
    logic              negMode;
    logic              bitVal;
  } aluStrobe_t;
endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  aluOp_e     opCode,
  input  logic [2:0] bitIdx,
  output aluStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    unique case (opCode)
      OP_ADD: begin strobe.flagMask = MASK_ARITH; strobe.resultWe = 1'b1; end
      OP_ADC: begin strobe.flagMask = MASK_ARITH; strobe.resultWe = 1'b1; strobe.carryUse = 1'b1; end
      OP_SUB: begin strobe.flagMask = MASK_ARITH; strobe.resultWe = 1'b1; strobe.subMode = 1'b1; end
      OP_SBC: begin
        strobe.flagMask = MASK_ARITH; strobe.resultWe = 1'b1; strobe.subMode = 1'b1;
        strobe.carryUse = 1'b1; strobe.zChain = 1'b1;
      end
      OP_CP:  begin strobe.flagMask = MASK_ARITH; strobe.subMode = 1'b1; end
      OP_CPC: begin
        strobe.flagMask = MASK_ARITH; strobe.subMode = 1'b1;
        strobe.carryUse = 1'b1; strobe.zChain = 1'b1;
      end
      OP_NEG: begin
        strobe.flagMask = MASK_ARITH; strobe.resultWe = 1'b1;
        strobe.subMode = 1'b1; strobe.negMode = 1'b1;
      end
      OP_AND, OP_OR, OP_EOR, OP_INC, OP_DEC, OP_TST: begin
        strobe.flagMask = MASK_LOGIC; strobe.resultWe = 1'b1;
      end
      OP_COM, OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
        strobe.flagMask = MASK_SHIFT; strobe.resultWe = 1'b1;
      end
      OP_SWAP, OP_SER: strobe.resultWe = 1'b1;
      OP_FSET: begin strobe.flagMask = FLAG_W'(1) << bitIdx; strobe.bitVal = 1'b1; end
      OP_FCLR: strobe.flagMask = FLAG_W'(1) << bitIdx;
      default: strobe = '0;
    endcase
  end
endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluOp_e            opCode,
  input  aluStrobe_t        strobe,
  input  logic [2:0]        bitIdx,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flagsCand
);
  localparam int NIB = DATA_W / 2;
  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {MSB{1'b0}}};
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {MSB{1'b1}}};

  logic              carryIn;
  logic [DATA_W-1:0] srcA, srcB;
  logic [DATA_W:0]   wideSum;
  logic [NIB:0]      halfSum;
  logic              arithOvf;
  logic              cNew, vNew, hNew, nNew, zNew;

  assign carryIn = strobe.carryUse & flagsIn[FLAG_C];
  assign srcA    = strobe.negMode ? '0  : opA;
  assign srcB    = strobe.negMode ? opA : opB;

  always_comb begin
    if (strobe.subMode) begin
      wideSum  = {1'b0, srcA} - {1'b0, srcB} - (DATA_W+1)'(carryIn);
      halfSum  = {1'b0, srcA[NIB-1:0]} - {1'b0, srcB[NIB-1:0]} - (NIB+1)'(carryIn);
      arithOvf = (srcA[MSB] & ~srcB[MSB] & ~wideSum[MSB]) | (~srcA[MSB] & srcB[MSB] & wideSum[MSB]);
    end else begin
      wideSum  = {1'b0, srcA} + {1'b0, srcB} + (DATA_W+1)'(carryIn);
      halfSum  = {1'b0, srcA[NIB-1:0]} + {1'b0, srcB[NIB-1:0]} + (NIB+1)'(carryIn);
      arithOvf = (srcA[MSB] & srcB[MSB] & ~wideSum[MSB]) | (~srcA[MSB] & ~srcB[MSB] & wideSum[MSB]);
    end
  end

  always_comb begin
    result = opA;
    cNew   = flagsIn[FLAG_C];
    vNew   = flagsIn[FLAG_V];
    hNew   = flagsIn[FLAG_H];
    unique case (opCode)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
        result = wideSum[DATA_W-1:0];
        cNew   = wideSum[DATA_W];
        hNew   = halfSum[NIB];
        vNew   = arithOvf;
      end
      OP_AND:  begin result = opA & opB; vNew = 1'b0; end
      OP_OR:   begin result = opA | opB; vNew = 1'b0; end
      OP_EOR:  begin result = opA ^ opB; vNew = 1'b0; end
      OP_TST:  vNew = 1'b0;
      OP_COM:  begin result = ~opA; cNew = 1'b1; vNew = 1'b0; end
      OP_INC:  begin result = opA + 1'b1; vNew = (result == MIN_NEG); end
      OP_DEC:  begin result = opA - 1'b1; vNew = (result == MAX_POS); end
      OP_LSL:  begin result = {opA[MSB-1:0], 1'b0};             cNew = opA[MSB]; vNew = result[MSB] ^ cNew; end
      OP_LSR:  begin result = {1'b0, opA[MSB:1]};               cNew = opA[0];   vNew = cNew; end
      OP_ROL:  begin result = {opA[MSB-1:0], flagsIn[FLAG_C]};  cNew = opA[MSB]; vNew = result[MSB] ^ cNew; end
      OP_ROR:  begin result = {flagsIn[FLAG_C], opA[MSB:1]};    cNew = opA[0];   vNew = result[MSB] ^ cNew; end
      OP_ASR:  begin result = {opA[MSB], opA[MSB:1]};           cNew = opA[0];   vNew = result[MSB] ^ cNew; end
      OP_SWAP: result = {opA[NIB-1:0], opA[MSB:NIB]};
      OP_SER:  result = '1;
      default: result = opA;
    endcase
    nNew = result[MSB];
    zNew = (result == '0) & (strobe.zChain ? flagsIn[FLAG_Z] : 1'b1);
  end

  always_comb begin
    flagsCand         = flagsIn;
    flagsCand[FLAG_C] = cNew;
    flagsCand[FLAG_Z] = zNew;
    flagsCand[FLAG_N] = nNew;
    flagsCand[FLAG_V] = vNew;
    flagsCand[FLAG_S] = nNew ^ vNew;
    flagsCand[FLAG_H] = hNew;
    if (opCode == OP_FSET || opCode == OP_FCLR) flagsCand[bitIdx] = strobe.bitVal;
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opValid,
  input  logic [OPC_W-1:0]  opSel,
  input  logic [2:0]        bitIdx,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              resultWe,
  output logic [FLAG_W-1:0] flags
);
  aluOp_e            opCode;
  aluStrobe_t        strobe;
  logic [FLAG_W-1:0] flagsCand, flagsNext;

  assign opCode = aluOp_e'(opSel);

  alu8_ctrl u_ctrl (
    .opCode (opCode),
    .bitIdx (bitIdx),
    .strobe (strobe)
  );

  alu8_datapath #(.DATA_W(DATA_W)) u_dp (
    .opCode    (opCode),
    .strobe    (strobe),
    .bitIdx    (bitIdx),
    .opA       (opA),
    .opB       (opB),
    .flagsIn   (flags),
    .result    (result),
    .flagsCand (flagsCand)
  );

  assign resultWe  = opValid & strobe.resultWe;
  assign flagsNext = (flags & ~strobe.flagMask) | (flagsCand & strobe.flagMask);

  always_ff @(posedge clk) begin
    if (!rst_n)       flags <= '0;
    else if (opValid) flags <= flagsNext;
  end

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !opValid |=> $stable(flags));

  assert_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
    opValid |=> (((flags ^ $past(flags)) & ~$past(strobe.flagMask)) == '0));

  assert_sign_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && strobe.flagMask[FLAG_N] && strobe.flagMask[FLAG_V])
      |=> (flags[FLAG_S] == (flags[FLAG_N] ^ flags[FLAG_V])));

  assert_zchain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && strobe.zChain && !flags[FLAG_Z]) |=> !flags[FLAG_Z]);

  assert_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && (opCode == OP_FSET || opCode == OP_FCLR))
      |=> ($countones(flags ^ $past(flags)) <= 1));

  assert_cmpwe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode == OP_CP || opCode == OP_CPC) |-> !resultWe);
endmodule

// File: tb/test_alu8_flags.sv
module test_alu8_flags;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       opValid = 1'b0;
  logic [4:0] opSel = '0;
  logic [2:0] bitIdx = '0;
  logic [7:0] opA = '0, opB = '0;
  logic [7:0] result;
  logic       resultWe;
  logic [7:0] flags;

  int  errCount = 0;
  int  chkCount = 0;
  bit  finished = 0;
  logic [7:0] modelFlags = 8'h00;

  always #2 clk = ~clk;

  alu8_flags i_alu8_flags (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opSel(opSel), .bitIdx(bitIdx),
    .opA(opA), .opB(opB), .result(result), .resultWe(resultWe), .flags(flags)
  );

  function automatic int toSigned(int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  // Behavioural reference: bit 7..0 = I T H S V N Z C
  function automatic void refModel(input int op, input int a, input int b, input int idx,
                                   input logic [7:0] f, output int r, output bit we,
                                   output logic [7:0] nf);
    int c, x, y, ci, d, sv;
    bit v, cy, writesNV;
    c = int'(f[0]); nf = f; r = a; we = 0; writesNV = 0; v = f[3]; cy = f[0];
    if (op <= 5 || op == 10) begin
      x  = (op == 10) ? 0 : a;
      y  = (op == 10) ? a : b;
      ci = (op == 1 || op == 3 || op == 5) ? c : 0;
      if (op == 0 || op == 1) begin
        d = x + y + ci; cy = d > 255;
        nf[5] = ((x & 15) + (y & 15) + ci) > 15;
        sv = toSigned(x) + toSigned(y) + ci;
      end else begin
        d = x - y - ci; cy = d < 0;
        nf[5] = ((x & 15) - (y & 15) - ci) < 0;
        sv = toSigned(x) - toSigned(y) - ci;
      end
      r = d & 255; v = (sv < -128) || (sv > 127);
      we = !(op == 4 || op == 5); writesNV = 1;
    end else begin
      writesNV = 1; we = 1;
      case (op)
        6:  begin r = a & b; v = 0; end
        7:  begin r = a | b; v = 0; end
        8:  begin r = a ^ b; v = 0; end
        9:  begin r = 255 - a; v = 0; cy = 1; end
        11: begin r = (a + 1) & 255; v = (r == 128); end
        12: begin r = (a + 255) & 255; v = (r == 127); end
        13: begin r = a; v = 0; end
        14: begin r = (a * 2) & 255; cy = a >= 128; end
        15: begin r = a / 2; cy = a % 2; end
        16: begin r = ((a * 2) & 255) + c; cy = a >= 128; end
        17: begin r = a / 2 + c * 128; cy = a % 2; end
        18: begin r = a / 2 + (a & 128); cy = a % 2; end
        19: begin r = (a % 16) * 16 + a / 16; writesNV = 0; end
        20: begin r = 255; writesNV = 0; end
        21: begin nf[idx] = 1'b1; writesNV = 0; we = 0; end
        22: begin nf[idx] = 1'b0; writesNV = 0; we = 0; end
        default: begin writesNV = 0; we = 0; end
      endcase
      if (op >= 14 && op <= 18) v = (r >= 128) ^ cy;
    end
    if (writesNV) begin
      nf[2] = r >= 128;
      nf[1] = (r == 0) && ((op == 3 || op == 5) ? f[1] : 1'b1);
      nf[3] = v;
      nf[4] = nf[2] ^ v;
      if ((op <= 10 && op != 6 && op != 7 && op != 8) || (op >= 14 && op <= 18)) nf[0] = cy;
    end
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    chkCount++;
    if (act != exp) begin
      errCount++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input int op, input int a, input int b, input int idx,
                      input bit valid, input string tag);
    int r; bit we; logic [7:0] nf;
    @(negedge clk);
    opSel = 5'(op); opA = 8'(a); opB = 8'(b); bitIdx = 3'(idx); opValid = valid;
    #1;
    refModel(op, a, b, idx, modelFlags, r, we, nf);
    check(tag, "result/we", {23'd0, resultWe, result}, {23'd0, we && valid, 8'(r)});
    @(posedge clk);
    #1;
    if (valid) modelFlags = nf;
    check(tag, "flags", int'(flags), int'(modelFlags));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errCount++; chkCount++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errCount, chkCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "reset flags", int'(flags), 0);
    // R2 add family
    step(0, 8'h0F, 8'h01, 0, 1, "R2");
    step(0, 8'h7F, 8'h01, 0, 1, "R2");
    step(0, 8'hFF, 8'h01, 0, 1, "R2");
    step(1, 8'h10, 8'h20, 0, 1, "R2");
    // R3 subtract and negate
    step(2, 8'h10, 8'h01, 0, 1, "R3");
    step(2, 8'h80, 8'h01, 0, 1, "R3");
    step(2, 8'h00, 8'h01, 0, 1, "R3");
    step(3, 8'h05, 8'h02, 0, 1, "R3");
    // R6 negate corners and complement
    step(10, 8'h80, 0, 0, 1, "R6");
    step(10, 8'h00, 0, 0, 1, "R6");
    step(10, 8'h01, 0, 0, 1, "R6");
    step(9, 8'h55, 0, 0, 1, "R6");
    // R4 chained compare over three bytes
    step(4, 8'h12, 8'h12, 0, 1, "R4");
    step(5, 8'h00, 8'h00, 0, 1, "R4");
    step(5, 8'h34, 8'h33, 0, 1, "R4");
    step(5, 8'h00, 8'h00, 0, 1, "R4");
    step(3, 8'h00, 8'h00, 0, 1, "R4");
    // R10 flag set then R5 logic
    step(21, 0, 0, 3, 1, "R10");
    step(21, 0, 0, 0, 1, "R10");
    step(6, 8'hF0, 8'h8F, 0, 1, "R5");
    step(7, 8'h00, 8'h00, 0, 1, "R5");
    step(8, 8'hAA, 8'h55, 0, 1, "R5");
    step(13, 8'h80, 0, 0, 1, "R5");
    // R7 increment / decrement
    step(11, 8'h7F, 0, 0, 1, "R7");
    step(11, 8'hFF, 0, 0, 1, "R7");
    step(12, 8'h80, 0, 0, 1, "R7");
    step(12, 8'h01, 0, 0, 1, "R7");
    // R8 shifts and rotates
    step(14, 8'hC1, 0, 0, 1, "R8");
    step(16, 8'h40, 0, 0, 1, "R8");
    step(17, 8'h02, 0, 0, 1, "R8");
    step(15, 8'h81, 0, 0, 1, "R8");
    step(18, 8'h81, 0, 0, 1, "R8");
    step(18, 8'h40, 0, 0, 1, "R8");
    // R9 swap and load-ones with flags seeded
    step(21, 0, 0, 5, 1, "R10");
    step(19, 8'hA5, 0, 0, 1, "R9");
    step(20, 8'h00, 0, 0, 1, "R9");
    // R10 every index set and clear
    for (int k = 0; k < 8; k++) step(21, 0, 0, k, 1, "R10");
    for (int k = 7; k >= 0; k--) step(22, 0, 0, k, 1, "R10");
    // R1 hold with opValid low, R2 unused codes
    step(0, 8'hFF, 8'hFF, 0, 0, "R1");
    step(25, 8'h3C, 8'h00, 0, 1, "R2");
    // R11 / R12 mixed sequence
    for (int n = 0; n < 4000; n++) begin
      int op;
      op = $urandom_range(0, 25);
      step(op, $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 7),
           ($urandom_range(0, 7) != 0), (n % 2 == 0) ? "R11" : "R12");
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end
endmodule